// File: doc/BRIEF.md
# I2C Target with General-Call Decoding

This block is an I2C target. It runs on a fast system clock that oversamples the open-drain SCL and SDA lines. It recognises its own address, either 7-bit or 10-bit. It acknowledges the bytes addressed to it, hands each received byte to the host with a one-cycle pulse, and shifts out a byte from a single holding register when the controller reads. SDA is pulled low through an output-enable signal, and the block never drives the line high.

Writes to address 0x00 are general calls. When general calls are enabled, the block acknowledges them and decodes the byte that follows:

- 0x06 restarts the bus logic.
- A byte equal to a programmed alternate identifier counts as a hardware general call, provided that mode is also enabled.
- Any other byte is reported as a plain general call.

The kind of call is written to a two-bit identifier field and a sticky status flag, and a pulse is raised. The host clears the flag and the field with a one-cycle clear strobe. A separate select input sets the moment of the transmit-request pulse. It comes either just after the SCL rise or just after the SCL fall of the acknowledge clock that comes before each read byte.

Top module: `i2c_gc_target`

## Requirements
- R1: While `slv_en` is low, `sda_oe` stays low, no byte is acknowledged and no interrupt pulses. Bus state is discarded.
- R2: In 7-bit mode (`addr10_en`=0), a first byte whose bits [7:1] equal `own_addr[6:0]` is acknowledged. Bit 0 of that byte set to 1 selects a read. Any other first byte is not acknowledged.
- R3: Each data byte written to an addressed target is acknowledged. It appears on `rx_data`, and `rx_irq` is high for exactly one cycle.
- R4: The first byte 0x00 is acknowledged only when `gc_en` is 1.
- R5: The byte after an acknowledged 0x00 sets `gc_stat` and pulses `gc_irq`. `gc_id` becomes 2 for 0x06 and 1 for any byte that is not a hardware match (for example 0x04). `gc_id` 0 means no call.
- R6: With `gc_en` and `hgc_en` both 1, a second byte equal to `alt_id` gives `gc_id` 3. With `hgc_en` 0, the same byte gives `gc_id` 1.
- R7: A 0x06 general call returns the bus logic to idle and empties the transmit holding register. `own_addr` and the enables keep their values, so the next transfer to the own address works.
- R8: A high `gc_clr` cycle sets `gc_stat` and `gc_id` to 0. Both are 0 after reset.
- R9: A read sends the holding-register byte MSB first. If nothing was written since the last byte was taken, 0xFF is sent.
- R10: After the controller NACKs a read byte, `sda_oe` stays low until the next START.
- R11: `tx_irq` is a one-cycle pulse for each read byte. With `early_tx`=1 it follows the SCL rise of the acknowledge clock before that byte. With `early_tx`=0 it follows the SCL fall that ends that clock.
- R12: In 10-bit mode, a write header 11110, `own_addr[9:8]`, 0 followed by a byte equal to `own_addr[7:0]` addresses the target. After a repeated START, the header with bit 0 = 1 reads from it. Outside that sequence, and for 7-bit style addresses, the target does not acknowledge.
- R13: A START or STOP in the middle of a byte drops that byte: no `rx_irq` and no acknowledge. After a START, address matching begins again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| sda_oe | output | 1 | High pulls SDA low |
| slv_en | input | 1 | Target enable |
| addr10_en | input | 1 | 10-bit address mode |
| gc_en | input | 1 | Acknowledge general calls |
| hgc_en | input | 1 | Hardware general-call recognition |
| early_tx | input | 1 | Transmit-request edge select (1 = SCL rise) |
| gc_clr | input | 1 | Clears general-call status and identifier |
| own_addr | input | 10 | Own address (7-bit mode uses bits 6:0) |
| alt_id | input | 8 | Alternate identifier for hardware general calls |
| tx_wr | input | 1 | Writes `tx_data` into the holding register |
| tx_data | input | 8 | Byte for the next read |
| rx_data | output | 8 | Last received data byte |
| rx_irq | output | 1 | One-cycle pulse per received byte |
| tx_irq | output | 1 | One-cycle transmit-request pulse |
| gc_irq | output | 1 | One-cycle general-call pulse |
| gc_stat | output | 1 | Sticky general-call status |
| gc_id | output | 2 | General-call kind: 0 none, 1 other, 2 reset, 3 hardware |

## Verification
The bench drives a table of write transfers. Each transfer pairs an address byte with a data byte.

- An own-address write against a near-miss address separates matching from accepting everything.
- General calls with second bytes 0x55, 0x04, 0x06 and the alternate identifier show whether each identifier code comes from its own byte rather than a fixed value.
- An own-address write placed after the 0x06 entry shows that the restart left the address in place.

Directed sequences cover the rest: reads from a loaded and from an empty holding register, controller NACK, both transmit-request edges, 10-bit addressing with a repeated START, disabled enables, and START or STOP in the middle of a byte.

// File: rtl/i2c_gc_pkg.sv
package i2c_gc_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_HDR,
    ST_HDR2,
    ST_RXD,
    ST_ACK,
    ST_TXD,
    ST_MACK,
    ST_SKIP
  } bus_st_e;

  typedef enum logic [1:0] {
    GCID_NONE  = 2'd0,
    GCID_OTHER = 2'd1,
    GCID_RESET = 2'd2,
    GCID_HW    = 2'd3
  } gc_id_e;

  localparam logic [7:0] GC_CMD_RESET = 8'h06;
  localparam logic [4:0] HDR10_TAG    = 5'b11110;

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] line_i,   // [0] SCL, [1] SDA
  output logic [1:0] line_s,
  output logic       scl_rise,
  output logic       scl_fall,
  output logic       start_det,
  output logic       stop_det
);

  logic [1:0] prev;

  for (genvar g = 0; g < 2; g++) begin : g_line
    logic [STAGES-1:0] sr;
    always_ff @(posedge clk) begin
      if (rst) sr <= '1;
      else     sr <= {sr[STAGES-2:0], line_i[g]};
    end
    assign line_s[g] = sr[STAGES-1];
  end

  always_ff @(posedge clk) begin
    if (rst) prev <= '1;
    else     prev <= line_s;
  end

  assign scl_rise  =  line_s[0] & ~prev[0];
  assign scl_fall  = ~line_s[0] &  prev[0];
  assign start_det =  line_s[0] &  prev[0] &  prev[1] & ~line_s[1];
  assign stop_det  =  line_s[0] &  prev[0] & ~prev[1] &  line_s[1];

endmodule

// File: rtl/i2c_gc_decode.sv
module i2c_gc_decode
  import i2c_gc_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic [DW-1:0] cmd,
  input  logic [DW-1:0] alt_id,
  input  logic          hgc_on,
  output gc_id_e        id
);

  always_comb begin
    if (hgc_on && cmd == alt_id)        id = GCID_HW;
    else if (cmd == DW'(GC_CMD_RESET))  id = GCID_RESET;
    else                                id = GCID_OTHER;
  end

endmodule

// File: rtl/i2c_tx_hold.sv
module i2c_tx_hold #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr,
  input  logic [DW-1:0] wdata,
  input  logic          take,
  input  logic          flush,
  output logic [DW-1:0] dout
);

  logic [DW-1:0] data_q;
  logic          full_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      data_q <= '0;
      full_q <= 1'b0;
    end else begin
      if (take) full_q <= 1'b0;
      if (wr) begin
        data_q <= wdata;
        full_q <= 1'b1;
      end
      if (flush) full_q <= 1'b0;
    end
  end

  assign dout = full_q ? data_q : '1;

endmodule

// File: rtl/i2c_gc_target.sv
module i2c_gc_target
  import i2c_gc_pkg::*;
#(
  parameter int DW          = 8,
  parameter int ADDR_W      = 10,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  input  logic              slv_en,
  input  logic              addr10_en,
  input  logic              gc_en,
  input  logic              hgc_en,
  input  logic              early_tx,
  input  logic              gc_clr,
  input  logic [ADDR_W-1:0] own_addr,
  input  logic [DW-1:0]     alt_id,
  input  logic              tx_wr,
  input  logic [DW-1:0]     tx_data,
  output logic [DW-1:0]     rx_data,
  output logic              rx_irq,
  output logic              tx_irq,
  output logic              gc_irq,
  output logic              gc_stat,
  output logic [1:0]        gc_id
);

  localparam int BCW = $clog2(DW + 1);
  localparam logic [BCW-1:0] FULL = BCW'(DW);
  localparam logic [BCW-1:0] LAST = BCW'(DW - 1);

  logic [1:0] line_s;
  logic       scl_rise, scl_fall, start_det, stop_det, sda_s;

  i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst      (rst),
    .line_i   ({sda_i, scl_i}),
    .line_s   (line_s),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .start_det(start_det),
    .stop_det (stop_det)
  );
  assign sda_s = line_s[1];

  bus_st_e        st, nxt_st, acc_nxt;
  logic [BCW-1:0] cnt;
  logic [DW-1:0]  sh;
  logic           drive, gc_pend, ten_ok, mack;
  logic           acc, set_gcp, set_ten, hdr10_hit;
  logic           live, byte_done, rx_evt, gc_evt, load_tx, flush_tx;
  logic [DW-1:0]  tx_dout;
  gc_id_e         gc_dec;

  i2c_gc_decode #(.DW(DW)) u_dec (
    .cmd   (sh),
    .alt_id(alt_id),
    .hgc_on(hgc_en & gc_en),
    .id    (gc_dec)
  );

  assign live      = slv_en & ~start_det & ~stop_det;
  assign byte_done = live & scl_fall & (cnt == FULL) &
                     (st == ST_HDR || st == ST_HDR2 || st == ST_RXD);
  assign rx_evt    = byte_done & (st == ST_RXD);
  assign gc_evt    = rx_evt & gc_pend;
  assign flush_tx  = gc_evt & (gc_dec == GCID_RESET);
  assign load_tx   = live & scl_fall &
                     ((st == ST_ACK && nxt_st == ST_TXD) || (st == ST_MACK && mack));

  i2c_tx_hold #(.DW(DW)) u_hold (
    .clk  (clk),
    .rst  (rst),
    .wr   (tx_wr),
    .wdata(tx_data),
    .take (load_tx),
    .flush(flush_tx),
    .dout (tx_dout)
  );

  assign hdr10_hit = addr10_en && (sh[DW-1:DW-5] == HDR10_TAG) &&
                     (sh[DW-6:DW-7] == own_addr[ADDR_W-1:ADDR_W-2]);

  // Accept / next-phase decision for the byte just shifted in
  always_comb begin
    acc     = 1'b0;
    acc_nxt = ST_RXD;
    set_gcp = 1'b0;
    set_ten = 1'b0;
    case (st)
      ST_HDR: begin
        if (gc_en && sh == '0) begin
          acc = 1'b1;
          set_gcp = 1'b1;
        end else if (!addr10_en && sh[DW-1:1] == own_addr[DW-2:0]) begin
          acc = 1'b1;
          acc_nxt = sh[0] ? ST_TXD : ST_RXD;
        end else if (hdr10_hit && !sh[0]) begin
          acc = 1'b1;
          acc_nxt = ST_HDR2;
        end else if (hdr10_hit && sh[0] && ten_ok) begin
          acc = 1'b1;
          acc_nxt = ST_TXD;
        end
      end
      ST_HDR2: begin
        if (sh == own_addr[DW-1:0]) begin
          acc = 1'b1;
          set_ten = 1'b1;
        end
      end
      ST_RXD: begin
        acc = 1'b1;
        if (gc_pend && gc_dec == GCID_RESET) acc_nxt = ST_IDLE;
      end
      default: ;
    endcase
  end

  // Bus state machine
  always_ff @(posedge clk) begin
    if (rst || !slv_en) begin
      st      <= ST_IDLE;
      nxt_st  <= ST_IDLE;
      cnt     <= '0;
      sh      <= '0;
      drive   <= 1'b0;
      gc_pend <= 1'b0;
      ten_ok  <= 1'b0;
      mack    <= 1'b0;
      rx_irq  <= 1'b0;
      tx_irq  <= 1'b0;
    end else begin
      rx_irq <= rx_evt;
      tx_irq <= 1'b0;
      if (start_det) begin
        st      <= ST_HDR;
        cnt     <= '0;
        drive   <= 1'b0;
        gc_pend <= 1'b0;
      end else if (stop_det) begin
        st      <= ST_IDLE;
        drive   <= 1'b0;
        gc_pend <= 1'b0;
        ten_ok  <= 1'b0;
      end else begin
        case (st)
          ST_HDR, ST_HDR2, ST_RXD: begin
            if (scl_rise && cnt != FULL) begin
              sh  <= {sh[DW-2:0], sda_s};
              cnt <= cnt + 1'b1;
            end else if (byte_done) begin
              cnt <= '0;
              if (acc) begin
                drive  <= 1'b1;
                st     <= ST_ACK;
                nxt_st <= acc_nxt;
                if (set_gcp) gc_pend <= 1'b1;
                if (st == ST_RXD) gc_pend <= 1'b0;
                if (st == ST_HDR && acc_nxt == ST_HDR2) ten_ok <= 1'b0;
                if (set_ten) ten_ok <= 1'b1;
              end else begin
                st <= ST_SKIP;
              end
            end
          end
          ST_ACK: begin
            if (scl_rise && early_tx && nxt_st == ST_TXD) tx_irq <= 1'b1;
            if (scl_fall) begin
              cnt <= '0;
              if (nxt_st == ST_TXD) begin
                sh    <= tx_dout;
                drive <= ~tx_dout[DW-1];
                st    <= ST_TXD;
                if (!early_tx) tx_irq <= 1'b1;
              end else begin
                drive <= 1'b0;
                st    <= nxt_st;
                if (nxt_st == ST_IDLE) ten_ok <= 1'b0;
              end
            end
          end
          ST_TXD: begin
            if (scl_fall) begin
              if (cnt == LAST) begin
                drive <= 1'b0;
                cnt   <= '0;
                st    <= ST_MACK;
              end else begin
                sh    <= {sh[DW-2:0], 1'b1};
                drive <= ~sh[DW-2];
                cnt   <= cnt + 1'b1;
              end
            end
          end
          ST_MACK: begin
            if (scl_rise) begin
              mack <= ~sda_s;
              if (early_tx && !sda_s) tx_irq <= 1'b1;
            end
            if (scl_fall) begin
              if (mack) begin
                sh    <= tx_dout;
                drive <= ~tx_dout[DW-1];
                st    <= ST_TXD;
                if (!early_tx) tx_irq <= 1'b1;
              end else begin
                drive <= 1'b0;
                st    <= ST_SKIP;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign sda_oe = drive;

  // Received byte register
  always_ff @(posedge clk) begin
    if (rst)         rx_data <= '0;
    else if (rx_evt) rx_data <= sh;
  end

  // General-call status and identifier
  always_ff @(posedge clk) begin
    if (rst) begin
      gc_stat <= 1'b0;
      gc_id   <= GCID_NONE;
      gc_irq  <= 1'b0;
    end else begin
      gc_irq <= gc_evt;
      if (gc_clr) begin
        gc_stat <= 1'b0;
        gc_id   <= GCID_NONE;
      end
      if (gc_evt) begin
        gc_stat <= 1'b1;
        gc_id   <= gc_dec;
      end
    end
  end

endmodule

// File: rtl/i2c_gc_target_chk.sv
module i2c_gc_target_chk (
  input logic       clk,
  input logic       rst,
  input logic       slv_en,
  input logic       gc_en,
  input logic       sda_oe,
  input logic       rx_irq,
  input logic       tx_irq,
  input logic       gc_irq,
  input logic       gc_clr,
  input logic       gc_stat,
  input logic [1:0] gc_id
);

  // R1
  disabled_release_chk: assert property (@(posedge clk) disable iff (rst)
    !slv_en |=> !sda_oe);

  // R3
  rx_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    rx_irq |=> !rx_irq);

  // R11
  tx_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    tx_irq |=> !tx_irq);

  // R4
  gc_needs_enable_chk: assert property (@(posedge clk) disable iff (rst)
    gc_irq |-> gc_en);

  // R5
  gc_status_set_chk: assert property (@(posedge clk) disable iff (rst)
    gc_irq |-> (gc_stat && gc_id != 2'd0));

  // R8
  gc_clear_chk: assert property (@(posedge clk) disable iff (rst)
    gc_clr |=> (gc_irq || (!gc_stat && gc_id == 2'd0)));

endmodule

bind i2c_gc_target i2c_gc_target_chk u_chk (
  .clk    (clk),
  .rst    (rst),
  .slv_en (slv_en),
  .gc_en  (gc_en),
  .sda_oe (sda_oe),
  .rx_irq (rx_irq),
  .tx_irq (tx_irq),
  .gc_irq (gc_irq),
  .gc_clr (gc_clr),
  .gc_stat(gc_stat),
  .gc_id  (gc_id)
);

// File: tb/sim_i2c_gc_target.sv
`timescale 1ns/1ps
module sim_i2c_gc_target;

  localparam int CLK_PERIOD = 10;
  localparam int HB = 16;
  localparam int NVEC = 7;
  // {addr byte, data byte, expected ack, expected gc_id}
  localparam logic [18:0] VEC [NVEC] = '{
    {8'h74, 8'hA5, 1'b1, 2'd0},
    {8'h76, 8'h3C, 1'b0, 2'd0},
    {8'h00, 8'h55, 1'b1, 2'd1},
    {8'h00, 8'h06, 1'b1, 2'd2},
    {8'h00, 8'h33, 1'b1, 2'd3},
    {8'h00, 8'h04, 1'b1, 2'd1},
    {8'h74, 8'h00, 1'b1, 2'd0}
  };

  logic clk = 1'b0, rst = 1'b1;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic sda_line, sda_oe;
  logic slv_en = 1'b1, addr10_en = 1'b0, gc_en = 1'b1, hgc_en = 1'b1;
  logic early_tx = 1'b0, gc_clr = 1'b0, tx_wr = 1'b0;
  logic [9:0] own_addr = 10'h03A;
  logic [7:0] alt_id = 8'h33, tx_data = 8'h00;
  logic [7:0] rx_data;
  logic rx_irq, tx_irq, gc_irq, gc_stat;
  logic [1:0] gc_id;

  int checks = 0, fails = 0;
  int rx_cnt = 0, tx_cnt = 0;
  logic [7:0] rx_last = 8'h00;
  logic tx_irq_scl = 1'b0;
  logic oe_while_off = 1'b0;
  logic done = 1'b0;

  assign sda_line = sda_m & ~sda_oe;

  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_gc_target u0 (
    .clk(clk), .rst(rst), .scl_i(scl_m), .sda_i(sda_line), .sda_oe(sda_oe),
    .slv_en(slv_en), .addr10_en(addr10_en), .gc_en(gc_en), .hgc_en(hgc_en),
    .early_tx(early_tx), .gc_clr(gc_clr), .own_addr(own_addr), .alt_id(alt_id),
    .tx_wr(tx_wr), .tx_data(tx_data), .rx_data(rx_data), .rx_irq(rx_irq),
    .tx_irq(tx_irq), .gc_irq(gc_irq), .gc_stat(gc_stat), .gc_id(gc_id)
  );

  always @(negedge clk) begin
    if (rx_irq) begin rx_cnt++; rx_last = rx_data; end
    if (tx_irq) begin tx_cnt++; tx_irq_scl = scl_m; end
    if (!slv_en && sda_oe && !rst) oe_while_off = 1'b1;
  end

  task automatic wcyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bus_start;
    sda_m = 1'b1; wcyc(HB/2);
    scl_m = 1'b1; wcyc(HB);
    sda_m = 1'b0; wcyc(HB);
    scl_m = 1'b0; wcyc(HB/2);
  endtask

  task automatic bus_stop;
    sda_m = 1'b0; wcyc(HB/2);
    scl_m = 1'b1; wcyc(HB);
    sda_m = 1'b1; wcyc(HB);
  endtask

  task automatic clk_bit(input logic b, output logic s);
    sda_m = b;    wcyc(HB/2);
    scl_m = 1'b1; wcyc(HB/2);
    s = sda_line; wcyc(HB/2);
    scl_m = 1'b0; wcyc(HB/2);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    logic s;
    for (int i = 7; i >= 0; i--) clk_bit(b[i], s);
    clk_bit(1'b1, s);
    ack = ~s;
  endtask

  task automatic recv_byte(output logic [7:0] b, input logic give_ack);
    logic s;
    for (int i = 7; i >= 0; i--) begin
      clk_bit(1'b1, s);
      b[i] = s;
    end
    clk_bit(~give_ack, s);
  endtask

  task automatic load_tx(input logic [7:0] v);
    tx_data = v; tx_wr = 1'b1; wcyc(1); tx_wr = 1'b0;
  endtask

  task automatic pulse_clr;
    gc_clr = 1'b1; wcyc(1); gc_clr = 1'b0; wcyc(1);
  endtask

  initial begin
    logic ack, s;
    logic [7:0] rb;
    int r0, t0;
    wcyc(5); rst = 1'b0; wcyc(5);

    // R8: reset state, plus idle bus
    check("R8 reset gc_id", gc_id, 0);
    check("R8 reset gc_stat", gc_stat, 0);
    check("R1 reset sda_oe", sda_oe, 0);
    check("R3 reset rx_data", rx_data, 0);

    // Table of write transfers: R2 R3 R4 R5 R6 R7
    for (int v = 0; v < NVEC; v++) begin
      pulse_clr();
      r0 = rx_cnt;
      bus_start();
      send_byte(VEC[v][18:11], ack);
      check($sformatf("R2/R4 vec%0d addr ack", v), ack, VEC[v][2]);
      if (ack) begin
        send_byte(VEC[v][10:3], ack);
        check($sformatf("R3 vec%0d data ack", v), ack, 1);
      end
      bus_stop(); wcyc(4);
      check($sformatf("R3 vec%0d rx count", v), rx_cnt - r0, VEC[v][2] ? 1 : 0);
      if (VEC[v][2]) check($sformatf("R3 vec%0d rx byte", v), rx_last, VEC[v][10:3]);
      check($sformatf("R5/R6 vec%0d gc_id", v), gc_id, VEC[v][1:0]);
    end

    // R8: clear after a general call
    bus_start(); send_byte(8'h00, ack); send_byte(8'h04, ack); bus_stop(); wcyc(4);
    check("R5 gc_stat set", gc_stat, 1);
    pulse_clr();
    check("R8 gc_stat cleared", gc_stat, 0);
    check("R8 gc_id cleared", gc_id, 0);

    // R6: hardware match disabled -> plain general call
    hgc_en = 1'b0;
    bus_start(); send_byte(8'h00, ack); send_byte(8'h33, ack); bus_stop(); wcyc(4);
    check("R6 hgc off gives id 1", gc_id, 1);
    hgc_en = 1'b1; pulse_clr();

    // R4: general calls disabled
    gc_en = 1'b0;
    bus_start(); send_byte(8'h00, ack); bus_stop(); wcyc(4);
    check("R4 gc disabled nack", ack, 0);
    check("R4 gc disabled no status", gc_stat, 0);
    gc_en = 1'b1;

    // R9 R10 R11: read with loaded byte, controller NACK, late request
    load_tx(8'hC3);
    t0 = tx_cnt;
    bus_start(); send_byte(8'h75, ack);
    check("R2 read addr ack", ack, 1);
    recv_byte(rb, 1'b0);
    check("R9 read loaded byte", rb, 8'hC3);
    check("R11 late tx_irq count", tx_cnt - t0, 1);
    check("R11 late tx_irq while scl low", tx_irq_scl, 0);
    check("R10 released after nack", sda_oe, 0);
    clk_bit(1'b1, s);
    check("R10 line stays high after nack", s, 1);
    bus_stop(); wcyc(4);

    // R9 R11: two bytes, second empty, early request
    early_tx = 1'b1;
    load_tx(8'h81);
    t0 = tx_cnt;
    bus_start(); send_byte(8'h75, ack);
    check("R11 early tx_irq while scl high", tx_irq_scl, 1);
    recv_byte(rb, 1'b1);
    check("R9 first read byte", rb, 8'h81);
    recv_byte(rb, 1'b0);
    check("R9 empty holding gives FF", rb, 8'hFF);
    check("R11 early tx_irq count", tx_cnt - t0, 2);
    bus_stop(); wcyc(4);
    early_tx = 1'b0;

    // R7: 0x06 empties the holding register
    load_tx(8'h5A);
    bus_start(); send_byte(8'h00, ack); send_byte(8'h06, ack); bus_stop(); wcyc(4);
    bus_start(); send_byte(8'h75, ack); recv_byte(rb, 1'b0); bus_stop(); wcyc(4);
    check("R7 holding flushed by reset call", rb, 8'hFF);
    check("R7 own address kept", ack, 1);
    pulse_clr();

    // R12: 10-bit addressing
    addr10_en = 1'b1; own_addr = 10'h2B5;
    r0 = rx_cnt;
    load_tx(8'h96);
    bus_start(); send_byte(8'hF4, ack);
    check("R12 10-bit header ack", ack, 1);
    send_byte(8'hB5, ack);
    check("R12 10-bit low byte ack", ack, 1);
    send_byte(8'h3E, ack); wcyc(4);
    check("R12 10-bit write data", rx_last, 8'h3E);
    bus_start(); send_byte(8'hF5, ack);
    check("R12 10-bit read header ack", ack, 1);
    recv_byte(rb, 1'b0);
    check("R12 10-bit read data", rb, 8'h96);
    bus_stop(); wcyc(4);
    bus_start(); send_byte(8'hF5, ack); bus_stop(); wcyc(4);
    check("R12 read header without write nack", ack, 0);
    bus_start(); send_byte(8'h6A, ack); bus_stop(); wcyc(4);
    check("R12 7-bit address in 10-bit mode nack", ack, 0);
    addr10_en = 1'b0; own_addr = 10'h03A;

    // R13: START and STOP in the middle of a data byte
    r0 = rx_cnt;
    bus_start(); send_byte(8'h74, ack);
    for (int i = 0; i < 4; i++) clk_bit(1'b1, s);
    bus_start(); send_byte(8'h74, ack);
    check("R13 address after mid-byte start", ack, 1);
    for (int i = 0; i < 3; i++) clk_bit(1'b0, s);
    bus_stop(); wcyc(4);
    check("R13 aborted bytes not received", rx_cnt - r0, 0);

    // R1: target disabled
    slv_en = 1'b0; wcyc(2);
    r0 = rx_cnt;
    bus_start(); send_byte(8'h74, ack); send_byte(8'h11, s); bus_stop(); wcyc(4);
    check("R1 disabled nack", ack, 0);
    check("R1 disabled no rx", rx_cnt - r0, 0);
    check("R1 disabled never drives", oe_while_off, 0);
    slv_en = 1'b1; wcyc(4);

    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule